// File: doc/BRIEF.md
# Tile Scroll Address Register Unit

This block keeps the scroll and video-memory address state of a tile-based picture generator. The state is a 15-bit working address, a 15-bit staged address, a 3-bit fine horizontal offset and a one-bit toggle that selects the first or second half of a two-step CPU write. The CPU side writes a control byte, a two-step scroll byte pair and a two-step address byte pair. All three merge bit fields into the staged address, and the scroll and address pairs share the toggle. The CPU side can also read status, which clears the toggle, and access the data port, which advances the working address.

The rendering side sends four strobes. Two step the working address horizontally or vertically across the tile grid with nametable wrap, and two copy the horizontal or vertical fields of the staged address into it. Each cycle the unit carries out at most one action, picked by a fixed priority. Every result appears on the outputs one clock after the strobe.

Address layout (bit positions are behaviour): bits 4:0 coarse column, bits 9:5 coarse row, bit 10 horizontal nametable, bit 11 vertical nametable, bits 14:12 fine row.

Top module: `scroll_addr_unit`

## Requirements
- R1: A synchronous active-low reset clears the working address, staged address, fine offset, toggle and load flag. It also clears the stored step-size bit, so the next linear data access adds 1.
- R2: A control write copies data bits 1:0 into staged bits 11:10 and leaves all other staged bits unchanged. It also stores data bit 2 as the step-size bit (1 selects a step of 32).
- R3: A scroll write with toggle 0 loads data bits 7:3 into staged bits 4:0 and data bits 2:0 into the fine offset, then sets the toggle.
- R4: A scroll write with toggle 1 loads data bits 2:0 into staged bits 14:12 and data bits 7:3 into staged bits 9:5, then clears the toggle.
- R5: An address write with toggle 0 loads data bits 5:0 into staged bits 13:8, forces staged bit 14 to 0 and sets the toggle.
- R6: An address write with toggle 1 loads the data into staged bits 7:0, copies the resulting staged value into the working address, clears the toggle and raises the load flag for exactly one cycle.
- R7: A status read clears the toggle and changes no address or offset.
- R8: A data access with the rendering input low adds 1 to the working address, or 32 when the step-size bit is set, and keeps only the low 14 bits of the sum.
- R9: A column step adds 1 to bits 4:0. When they hold 31, it clears them and inverts bit 10.
- R10: A row step adds 1 to bits 14:12 while they are below 7. When they hold 7, it clears them and advances bits 9:5: 29 becomes 0 and bit 11 inverts, 31 becomes 0 with no inversion, and any other value increments.
- R11: A horizontal copy moves staged bits under mask 0x041F into the working address. A vertical copy moves staged bits under mask 0x7BE0. All other working bits are kept.
- R12: A data access with the rendering input high performs a column step and then a row step, instead of the linear step.
- R13: When several requests arrive in one cycle, only the first in this order takes effect: control write, scroll write, address write, status read, data access, column step, row step, horizontal copy, vertical copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_ctrl_we | input | 1 | Control byte write strobe |
| cpu_scroll_we | input | 1 | Scroll byte write strobe |
| cpu_addr_we | input | 1 | Address byte write strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_status_rd | input | 1 | Status read strobe |
| cpu_data_acc | input | 1 | Data port access strobe |
| rendering | input | 1 | High while the picture generator is fetching |
| rnd_step_col | input | 1 | Column step strobe |
| rnd_step_row | input | 1 | Row step strobe |
| rnd_copy_h | input | 1 | Horizontal field copy strobe |
| rnd_copy_v | input | 1 | Vertical field copy strobe |
| vaddr | output | 15 | Working address |
| taddr | output | 15 | Staged address |
| fine_x | output | 3 | Fine horizontal offset |
| wtoggle | output | 1 | Two-step write toggle |
| v_loaded | output | 1 | One-cycle pulse after the working address is loaded from the staged address |

## Verification
The bench sweeps every column value on both horizontal nametables, and every fine row and coarse row on both vertical nametables. This covers rows 29 and 31: a design that treated 31 like 29 would flip the vertical nametable, and one that wrapped only at 31 would run into the attribute rows. All 256 scroll byte pairs are written, so a swapped or shifted field lands in the wrong staged bits. The linear step is checked at the top of the 14-bit range, so a carry into bit 14 becomes visible. The bench also checks that a status read between two scroll writes restarts the pair, that reset restores a step of 1, and that simultaneous strobes resolve by priority. A wrong priority would move the address twice or lose a CPU write.

// File: rtl/scroll_addr_pkg.sv
// Package: shared widths, field positions and the action code used by the
// scroll/address unit. Assumes the fixed 15-bit tile address layout.
package scroll_addr_pkg;
    localparam int ADDR_W   = 15;
    localparam int DATA_W   = 8;
    localparam int FINE_W   = 3;
    localparam int CX_LSB   = 0;
    localparam int CX_W     = 5;
    localparam int CY_LSB   = 5;
    localparam int CY_W     = 5;
    localparam int NT_H_BIT = 10;
    localparam int NT_V_BIT = 11;
    localparam int FY_LSB   = 12;
    localparam int FY_W     = 3;
    localparam int LIN_W    = 14;
    localparam int CY_SWAP  = 29;
    localparam int CY_LAST  = (1 << CY_W) - 1;
    localparam int CX_LAST  = (1 << CX_W) - 1;
    localparam int FY_LAST  = (1 << FY_W) - 1;
    localparam logic [ADDR_W-1:0] H_MASK = 15'h041F;
    localparam logic [ADDR_W-1:0] V_MASK = 15'h7BE0;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CTRL,
        OP_SCROLL,
        OP_ADDR,
        OP_STATUS,
        OP_DATA_LIN,
        OP_DATA_REND,
        OP_STEP_COL,
        OP_STEP_ROW,
        OP_COPY_H,
        OP_COPY_V
    } scroll_op_e;
endpackage

// File: rtl/scroll_op_arbiter.sv
// Picks the single action taken this cycle from all request strobes using a
// fixed priority. Assumes strobes are single-cycle and synchronous to clk.
module scroll_op_arbiter
    import scroll_addr_pkg::*;
(
    input  logic       ctrl_we,
    input  logic       scroll_we,
    input  logic       addr_we,
    input  logic       status_rd,
    input  logic       data_acc,
    input  logic       rendering,
    input  logic       step_col,
    input  logic       step_row,
    input  logic       copy_h,
    input  logic       copy_v,
    output scroll_op_e op
);
    // Priority chain: CPU writes, status, data access, then rendering strobes.
    always_comb begin
        if (ctrl_we)        op = OP_CTRL;
        else if (scroll_we) op = OP_SCROLL;
        else if (addr_we)   op = OP_ADDR;
        else if (status_rd) op = OP_STATUS;
        else if (data_acc)  op = rendering ? OP_DATA_REND : OP_DATA_LIN;
        else if (step_col)  op = OP_STEP_COL;
        else if (step_row)  op = OP_STEP_ROW;
        else if (copy_h)    op = OP_COPY_H;
        else if (copy_v)    op = OP_COPY_V;
        else                op = OP_NONE;
    end
endmodule

// File: rtl/scroll_t_merge.sv
// Computes the next staged address, fine offset and toggle for CPU-side
// actions. Assumes op is already arbitrated; asserts load_v on the second
// address byte so the top copies the new staged value into the working one.
module scroll_t_merge
    import scroll_addr_pkg::*;
(
    input  scroll_op_e         op,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]  t_cur,
    input  logic [FINE_W-1:0]  fx_cur,
    input  logic               w_cur,
    output logic [ADDR_W-1:0]  t_nxt,
    output logic [FINE_W-1:0]  fx_nxt,
    output logic               w_nxt,
    output logic               load_v
);
    // Field merge for control, scroll and address writes; status clears toggle.
    always_comb begin
        t_nxt  = t_cur;
        fx_nxt = fx_cur;
        w_nxt  = w_cur;
        load_v = 1'b0;
        case (op)
            OP_CTRL: begin
                t_nxt[NT_V_BIT:NT_H_BIT] = wdata[1:0];
            end
            OP_SCROLL: begin
                if (!w_cur) begin
                    t_nxt[CX_LSB +: CX_W] = wdata[DATA_W-1 -: CX_W];
                    fx_nxt                = wdata[FINE_W-1:0];
                    w_nxt                 = 1'b1;
                end else begin
                    t_nxt[FY_LSB +: FY_W] = wdata[FY_W-1:0];
                    t_nxt[CY_LSB +: CY_W] = wdata[DATA_W-1 -: CY_W];
                    w_nxt                 = 1'b0;
                end
            end
            OP_ADDR: begin
                if (!w_cur) begin
                    t_nxt[ADDR_W-2:DATA_W] = wdata[ADDR_W-2-DATA_W:0];
                    t_nxt[ADDR_W-1]        = 1'b0;
                    w_nxt                  = 1'b1;
                end else begin
                    t_nxt[DATA_W-1:0] = wdata;
                    w_nxt             = 1'b0;
                    load_v            = 1'b1;
                end
            end
            OP_STATUS: begin
                w_nxt = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/scroll_v_step.sv
// Computes the next working address for data accesses and rendering strobes:
// linear +1/+32 step, tile-grid column/row steps and staged-field copies.
// Assumes op is already arbitrated; CPU write actions leave v unchanged here.
module scroll_v_step
    import scroll_addr_pkg::*;
(
    input  scroll_op_e         op,
    input  logic [ADDR_W-1:0]  v_cur,
    input  logic [ADDR_W-1:0]  t_cur,
    input  logic               step32,
    output logic [ADDR_W-1:0]  v_nxt
);
    // Column step: advance coarse column, wrap into the other horizontal table.
    function automatic logic [ADDR_W-1:0] col_step(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        if (a[CX_LSB +: CX_W] == CX_W'(CX_LAST)) begin
            r[CX_LSB +: CX_W] = '0;
            r[NT_H_BIT]       = ~a[NT_H_BIT];
        end else begin
            r[CX_LSB +: CX_W] = a[CX_LSB +: CX_W] + 1'b1;
        end
        return r;
    endfunction

    // Row step: fine row first, then coarse row with the 29/31 wrap rules.
    function automatic logic [ADDR_W-1:0] row_step(input logic [ADDR_W-1:0] a);
        logic [ADDR_W-1:0] r;
        r = a;
        if (a[FY_LSB +: FY_W] != FY_W'(FY_LAST)) begin
            r[FY_LSB +: FY_W] = a[FY_LSB +: FY_W] + 1'b1;
        end else begin
            r[FY_LSB +: FY_W] = '0;
            if (a[CY_LSB +: CY_W] == CY_W'(CY_SWAP)) begin
                r[CY_LSB +: CY_W] = '0;
                r[NT_V_BIT]       = ~a[NT_V_BIT];
            end else if (a[CY_LSB +: CY_W] == CY_W'(CY_LAST)) begin
                r[CY_LSB +: CY_W] = '0;
            end else begin
                r[CY_LSB +: CY_W] = a[CY_LSB +: CY_W] + 1'b1;
            end
        end
        return r;
    endfunction

    logic [ADDR_W-1:0] lin_sum;

    // Linear data-port step, truncated to the 14-bit memory range.
    always_comb begin
        lin_sum = v_cur + (step32 ? ADDR_W'(32) : ADDR_W'(1));
        lin_sum[ADDR_W-1:LIN_W] = '0;
    end

    // Select the working-address update for the arbitrated action.
    always_comb begin
        case (op)
            OP_DATA_LIN:  v_nxt = lin_sum;
            OP_DATA_REND: v_nxt = row_step(col_step(v_cur));
            OP_STEP_COL:  v_nxt = col_step(v_cur);
            OP_STEP_ROW:  v_nxt = row_step(v_cur);
            OP_COPY_H:    v_nxt = (v_cur & ~H_MASK) | (t_cur & H_MASK);
            OP_COPY_V:    v_nxt = (v_cur & ~V_MASK) | (t_cur & V_MASK);
            default:      v_nxt = v_cur;
        endcase
    end
endmodule

// File: rtl/scroll_addr_unit.sv
// Top of the scroll/address register unit. Holds working address, staged
// address, fine offset, toggle and step-size bit; one action per cycle.
// Assumes a synchronous active-low reset and single-cycle request strobes.
module scroll_addr_unit
    import scroll_addr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_ctrl_we,
    input  logic               cpu_scroll_we,
    input  logic               cpu_addr_we,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_status_rd,
    input  logic               cpu_data_acc,
    input  logic               rendering,
    input  logic               rnd_step_col,
    input  logic               rnd_step_row,
    input  logic               rnd_copy_h,
    input  logic               rnd_copy_v,
    output logic [ADDR_W-1:0]  vaddr,
    output logic [ADDR_W-1:0]  taddr,
    output logic [FINE_W-1:0]  fine_x,
    output logic               wtoggle,
    output logic               v_loaded
);
    scroll_op_e        op;
    logic              step32;
    logic [ADDR_W-1:0] t_nxt;
    logic [FINE_W-1:0] fx_nxt;
    logic              w_nxt;
    logic              load_v;
    logic [ADDR_W-1:0] v_step_nxt;

    scroll_op_arbiter u_arb (
        .ctrl_we   (cpu_ctrl_we),
        .scroll_we (cpu_scroll_we),
        .addr_we   (cpu_addr_we),
        .status_rd (cpu_status_rd),
        .data_acc  (cpu_data_acc),
        .rendering (rendering),
        .step_col  (rnd_step_col),
        .step_row  (rnd_step_row),
        .copy_h    (rnd_copy_h),
        .copy_v    (rnd_copy_v),
        .op        (op)
    );

    scroll_t_merge u_tm (
        .op     (op),
        .wdata  (cpu_wdata),
        .t_cur  (taddr),
        .fx_cur (fine_x),
        .w_cur  (wtoggle),
        .t_nxt  (t_nxt),
        .fx_nxt (fx_nxt),
        .w_nxt  (w_nxt),
        .load_v (load_v)
    );

    scroll_v_step u_vs (
        .op     (op),
        .v_cur  (vaddr),
        .t_cur  (taddr),
        .step32 (step32),
        .v_nxt  (v_step_nxt)
    );

    // State registers: reset clears all, otherwise take the arbitrated update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr    <= '0;
            taddr    <= '0;
            fine_x   <= '0;
            wtoggle  <= 1'b0;
            v_loaded <= 1'b0;
            step32   <= 1'b0;
        end else begin
            taddr    <= t_nxt;
            fine_x   <= fx_nxt;
            wtoggle  <= w_nxt;
            v_loaded <= load_v;
            vaddr    <= load_v ? t_nxt : v_step_nxt;
            if (op == OP_CTRL) step32 <= cpu_wdata[2];
        end
    end

    // R2
    ctrl_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CTRL) |=> (taddr[11:10] == $past(cpu_wdata[1:0]))
                          && (taddr[9:0] == $past(taddr[9:0]))
                          && (taddr[14:12] == $past(taddr[14:12])));

    // R3
    scroll_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_SCROLL && !wtoggle) |=> wtoggle && (fine_x == $past(cpu_wdata[2:0])));

    // R5
    addr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ADDR && !wtoggle) |=> wtoggle && !taddr[14]);

    // R6
    load_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_loaded |-> (vaddr == taddr) && !wtoggle);

    // R6
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        v_loaded |=> !v_loaded || $past(op == OP_ADDR));

    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STATUS) |=> !wtoggle && $stable(vaddr) && $stable(taddr));

    // R8
    lin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DATA_LIN) |=> !vaddr[14]);

    // R9
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_STEP_COL && vaddr[4:0] == 5'd31)
            |=> (vaddr[4:0] == 5'd0) && (vaddr[10] != $past(vaddr[10])));

    // R13
    cpu_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ctrl_we || cpu_scroll_we || cpu_addr_we) && !(cpu_addr_we && !cpu_ctrl_we && !cpu_scroll_we && wtoggle)
            |=> $stable(vaddr));
endmodule

// File: tb/scroll_addr_unit_test.sv
module scroll_addr_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_ctrl_we = 0, cpu_scroll_we = 0, cpu_addr_we = 0;
    logic [7:0]  cpu_wdata = 0;
    logic        cpu_status_rd = 0, cpu_data_acc = 0, rendering = 0;
    logic        rnd_step_col = 0, rnd_step_row = 0, rnd_copy_h = 0, rnd_copy_v = 0;
    logic [14:0] vaddr, taddr;
    logic [2:0]  fine_x;
    logic        wtoggle, v_loaded;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // Reference state
    int mv = 0, mt = 0, mx = 0, mw = 0, ms = 0, ml = 0;

    always #10 clk = ~clk;

    scroll_addr_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cpu_ctrl_we(cpu_ctrl_we), .cpu_scroll_we(cpu_scroll_we), .cpu_addr_we(cpu_addr_we),
        .cpu_wdata(cpu_wdata), .cpu_status_rd(cpu_status_rd), .cpu_data_acc(cpu_data_acc),
        .rendering(rendering), .rnd_step_col(rnd_step_col), .rnd_step_row(rnd_step_row),
        .rnd_copy_h(rnd_copy_h), .rnd_copy_v(rnd_copy_v),
        .vaddr(vaddr), .taddr(taddr), .fine_x(fine_x), .wtoggle(wtoggle), .v_loaded(v_loaded)
    );

    function automatic int m_col(input int a);
        int c = a % 32;
        if (c == 31) return (a - 31) ^ 1024;
        return a + 1;
    endfunction

    function automatic int m_row(input int a);
        int f = (a / 4096) % 8;
        int c = (a / 32) % 32;
        if (f < 7) return a + 4096;
        a = a - 7 * 4096;
        if (c == 29) return (a - 29 * 32) ^ 2048;
        if (c == 31) return a - 31 * 32;
        return a + 32;
    endfunction

    // Update the reference from the currently driven strobes.
    function automatic void model_update();
        int d = int'(cpu_wdata);
        ml = 0;
        if (cpu_ctrl_we) begin
            mt = (mt & ~32'h0C00) | ((d % 4) * 1024);
            ms = (d / 4) % 2;
        end else if (cpu_scroll_we) begin
            if (mw == 0) begin
                mt = (mt & ~32'h001F) | (d / 8);
                mx = d % 8; mw = 1;
            end else begin
                mt = (mt & ~32'h73E0) | ((d % 8) * 4096) | ((d / 8) * 32);
                mw = 0;
            end
        end else if (cpu_addr_we) begin
            if (mw == 0) begin
                mt = (mt % 256) | ((d % 64) * 256);
                mw = 1;
            end else begin
                mt = (mt & ~32'h00FF) | d;
                mv = mt; mw = 0; ml = 1;
            end
        end else if (cpu_status_rd) begin
            mw = 0;
        end else if (cpu_data_acc) begin
            if (rendering) mv = m_row(m_col(mv));
            else mv = (mv + (ms ? 32 : 1)) % 16384;
        end else if (rnd_step_col) mv = m_col(mv);
        else if (rnd_step_row) mv = m_row(mv);
        else if (rnd_copy_h) mv = (mv & ~32'h041F) | (mt & 32'h041F);
        else if (rnd_copy_v) mv = (mv & ~32'h7BE0) | (mt & 32'h7BE0);
    endfunction

    task automatic compare(input string tag);
        n_chk++;
        if (vaddr !== 15'(mv) || taddr !== 15'(mt) || fine_x !== 3'(mx) ||
            wtoggle !== 1'(mw) || v_loaded !== 1'(ml)) begin
            n_fail++;
            $display("FAIL %s: actual v=%h t=%h x=%0d w=%b ld=%b expected v=%h t=%h x=%0d w=%0d ld=%0d",
                     tag, vaddr, taddr, fine_x, wtoggle, v_loaded,
                     15'(mv), 15'(mt), mx, mw, ml);
        end
    endtask

    task automatic clear_in();
        cpu_ctrl_we = 0; cpu_scroll_we = 0; cpu_addr_we = 0; cpu_status_rd = 0;
        cpu_data_acc = 0; rnd_step_col = 0; rnd_step_row = 0; rnd_copy_h = 0; rnd_copy_v = 0;
    endtask

    // Apply driven strobes for one edge, then check at the following negedge.
    task automatic step(input string tag);
        model_update();
        @(posedge clk);
        @(negedge clk);
        clear_in();
        compare(tag);
    endtask

    task automatic wr_ctrl(input int d, input string tag);
        cpu_wdata = 8'(d); cpu_ctrl_we = 1; step(tag);
    endtask
    task automatic wr_scroll(input int d, input string tag);
        cpu_wdata = 8'(d); cpu_scroll_we = 1; step(tag);
    endtask
    task automatic wr_addr(input int d, input string tag);
        cpu_wdata = 8'(d); cpu_addr_we = 1; step(tag);
    endtask
    task automatic rd_status(input string tag);
        cpu_status_rd = 1; step(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        mv = 0; mt = 0; mx = 0; mw = 0; ms = 0; ml = 0;
        compare(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset("R1 reset state");

        // R5 R6: seed staged and working address
        wr_addr(8'h3F, "R5 first addr");
        wr_addr(8'hFF, "R6 second addr");
        step("R6 load pulse drops");
        // R2: control merges only nametable bits
        wr_ctrl(8'h00, "R2 ctrl 00");
        wr_ctrl(8'h03, "R2 ctrl 03");
        wr_ctrl(8'hFA, "R2 ctrl FA");

        // R3 R4: every scroll byte as first and second write
        for (int d = 0; d < 256; d++) begin
            wr_scroll(d, "R3 scroll first");
            wr_scroll(255 - d, "R4 scroll second");
        end

        // R5: staged bit 14 forced low
        rd_status("R7 status");
        wr_scroll(0, "R3 scroll first");
        wr_scroll(8'h07, "R4 set fine row 7");
        wr_addr(8'hFF, "R5 addr clears bit14");
        wr_addr(8'h5A, "R6 second addr");

        // R7: status read restarts a pair
        wr_scroll(8'hAB, "R3 scroll first");
        rd_status("R7 status clears toggle");
        wr_scroll(8'h13, "R7 scroll acts as first");
        rd_status("R7 status");

        // R8: linear step and 14-bit truncation
        wr_ctrl(0, "R2 step 1");
        wr_addr(8'h3F, "R5"); wr_addr(8'hFF, "R6");
        cpu_data_acc = 1; step("R8 wrap at 3FFF +1");
        cpu_data_acc = 1; step("R8 +1");
        wr_ctrl(4, "R2 step 32");
        wr_addr(8'h3F, "R5"); wr_addr(8'hF0, "R6");
        cpu_data_acc = 1; step("R8 wrap +32");
        cpu_data_acc = 1; step("R8 +32");

        // R1: reset restores step of 1
        do_reset("R1 reset mid-run");
        cpu_data_acc = 1; step("R1 step back to 1");

        // R9: column sweep on both horizontal tables
        for (int nt = 0; nt < 2; nt++)
            for (int cx = 0; cx < 32; cx++) begin
                wr_addr(nt * 4, "R5"); wr_addr(cx + 64, "R6");
                rnd_step_col = 1; step("R9 column step");
            end

        // R10 R11: fine/coarse row sweep on both vertical tables
        for (int nt = 0; nt < 2; nt++)
            for (int cy = 0; cy < 32; cy++)
                for (int fy = 0; fy < 8; fy++) begin
                    wr_ctrl(nt * 2 + 1, "R2");
                    rd_status("R7");
                    wr_scroll(8'h55, "R3");
                    wr_scroll(cy * 8 + fy, "R4");
                    rnd_copy_v = 1; step("R11 vertical copy");
                    rnd_step_row = 1; step("R10 row step");
                end

        // R11: horizontal copy with varied staged values
        for (int k = 0; k < 16; k++) begin
            wr_addr(k * 3 + 1, "R5"); wr_addr(k * 17, "R6");
            wr_ctrl(k, "R2");
            rd_status("R7");
            wr_scroll(255 - k * 13, "R3");
            rnd_copy_h = 1; step("R11 horizontal copy");
        end

        // R12: rendering data access wraps both axes
        rd_status("R7");
        wr_scroll(8'hF8, "R3");
        wr_scroll(8'hEF, "R4 row 29 fine 7");
        rnd_copy_v = 1; step("R11");
        rnd_copy_h = 1; step("R11");
        rendering = 1;
        cpu_data_acc = 1; step("R12 rendering access wrap");
        cpu_data_acc = 1; step("R12 rendering access");
        rendering = 0;

        // R13: simultaneous requests
        cpu_scroll_we = 1; cpu_status_rd = 1; cpu_data_acc = 1; cpu_wdata = 8'h21;
        step("R13 scroll beats status and data");
        cpu_status_rd = 1; cpu_data_acc = 1; step("R13 status beats data");
        cpu_data_acc = 1; rnd_step_col = 1; step("R13 data beats column");
        rnd_step_col = 1; rnd_step_row = 1; step("R13 column beats row");
        rnd_step_row = 1; rnd_copy_h = 1; step("R13 row beats copy");
        rnd_copy_h = 1; rnd_copy_v = 1; step("R13 horizontal beats vertical");
        cpu_ctrl_we = 1; cpu_addr_we = 1; cpu_wdata = 8'h02; step("R13 ctrl beats addr");
        wr_addr(8'h12, "R5");
        cpu_addr_we = 1; rnd_step_col = 1; cpu_wdata = 8'h34; step("R13 addr beats column");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule